// File: doc/BRIEF.md
# Streaming Sliding-Window Convolution Engine

This block computes a two-dimensional convolution over an image that arrives as a stream of signed 8-bit pixels in raster order. It produces one result only for each window position that lies wholly inside the image, so no edge padding is used. The window has ROWS rows and COLS columns. Both are set at elaboration and are independent of each other, so square, rectangular and single-row (1×N, one-dimensional) windows all come from the same source. The image width and height are runtime inputs. A single-cycle frame-start pulse clears the internal row and column position, and the position also wraps to the origin on its own after the last pixel of a frame.

Each window row except the newest has its own one-line buffer, indexed by the current column. Pixels are therefore only ever read and written at the column being received, with no address jumps. A shift-register window feeds a fully parallel multiplier array, followed by a two-level registered adder tree. The arithmetic pipeline sees only clock, reset and a single advance enable. A control unit tracks the pixel position, marks which positions yield results, and turns downstream backpressure into a freeze of the whole datapath. The ROWS×COLS signed weights sit in a register bank written through a simple address/data port while no frame is in flight.

Top module: `conv_stream_engine`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `res_valid` and `res_last` are 0 and `pix_ready` is 1.
- R2: For an image of width W and height H (COLS ≤ W ≤ MAX_W, ROWS ≤ H), exactly (H−ROWS+1)×(W−COLS+1) results are emitted, in raster order of the window's top-left corner (pr, pc). Each result equals Σ x[pr+i][pc+j]·w[i][j], and no padded positions are emitted.
- R3: Take the clock edge that accepts the bottom-right pixel of a window. When output is not stalled, that window's result is on `res_data` with `res_valid` high after the third edge following it. Gap-free input gives one result per cycle along a row.
- R4: Weight w[i][j] is written at `coef_addr` = i·COLS + j, where i counts window rows from the top and j counts columns from the left. Weights and pixels are two's-complement 8-bit values.
- R5: `res_data` is a signed value of 16 + ceil(log2(ROWS·COLS)) bits holding the exact sum, with no wrap, even when every product is the extreme +16384 or −16256.
- R6: While `res_valid` is high and `res_ready` is low, `pix_ready` is low, and `res_data`/`res_last` keep their values into the next cycle. No result is lost or duplicated.
- R7: `res_last` is high only with the final result of a frame, the one at pr = H−ROWS and pc = W−COLS.
- R8: Idle cycles on the input (`pix_valid` low) produce no result and do not alter any later result.
- R9: A `frame_start` pulse returns the pixel position to row 0, column 0, discarding a partly received frame. The position also returns there by itself after the last pixel of a frame, so the next frame may start without a pulse and with new dimensions. The pulse must not fall in a cycle that transfers a pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Clears the pixel position to the frame origin |
| img_width | input | DIM_W | Pixels per image line (COLS..MAX_W) |
| img_height | input | DIM_W | Lines per image (at least ROWS) |
| coef_we | input | 1 | Weight write strobe |
| coef_addr | input | ceil(log2(ROWS·COLS)), min 1 | Weight index i·COLS+j |
| coef_data | input | 8 | Signed weight value |
| pix_valid | input | 1 | Input pixel valid |
| pix_ready | output | 1 | Input pixel accepted when high with pix_valid |
| pix_data | input | 8 | Signed input pixel |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Downstream accepts the result |
| res_data | output | 16+ceil(log2(ROWS·COLS)) | Signed full-precision convolution result |
| res_last | output | 1 | Marks the final result of a frame |

## Verification
For each window, the bench records the cycle in which its bottom-right pixel was accepted. When no backpressure is applied, it requires the matching result to appear exactly three edges later. All sampling is done half a period after an edge, so the value checked is the one settled by that edge. Under random stalls the latency is not fixed, so the checks move to ordering and value. The bench looks one sampling point after each stalled cycle and requires the output to hold. Result counts are compared only after the pipeline has had several idle cycles to drain, so a late extra result is still caught.

// File: rtl/conv_pkg.sv
package conv_pkg;

    localparam int PIX_W  = 8;
    localparam int PROD_W = 2 * PIX_W;

    typedef logic signed [PIX_W-1:0]  pix_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    // Marker that travels alongside a window through the pipeline
    typedef struct packed {
        logic valid;
        logic last;
    } tag_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Full-precision width of a sum of rows*cols products
    function automatic int acc_width(input int rows, input int cols);
        return PROD_W + $clog2(rows * cols);
    endfunction

endpackage

// File: rtl/conv_ctrl.sv
module conv_ctrl
    import conv_pkg::*;
#(
    parameter int ROWS  = 2,
    parameter int COLS  = 3,
    parameter int MAX_W = 64,
    parameter int DIM_W = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         frame_start,
    input  logic [DIM_W-1:0]             img_w,
    input  logic [DIM_W-1:0]             img_h,
    input  logic                         in_valid,
    input  logic                         out_valid,
    input  logic                         out_ready,
    output logic                         in_ready,
    output logic                         adv,
    output logic                         push,
    output logic [idx_width(MAX_W)-1:0]  col_idx,
    output tag_t                         tag_o
);

    localparam int CW = idx_width(MAX_W);

    logic [DIM_W-1:0] col_q, row_q;
    logic             end_col, end_row, in_win;
    tag_t             tag_q;

    // Whole datapath freezes only when a result is waiting and refused
    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;
    assign push     = in_valid && adv;

    assign end_col = (col_q == img_w - DIM_W'(1));
    assign end_row = (row_q == img_h - DIM_W'(1));
    assign in_win  = (row_q >= DIM_W'(ROWS - 1)) && (col_q >= DIM_W'(COLS - 1));
    assign col_idx = col_q[CW-1:0];

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            col_q <= '0;
            row_q <= '0;
        end else if (push) begin
            if (end_col) begin
                col_q <= '0;
                row_q <= end_row ? '0 : row_q + DIM_W'(1);
            end else begin
                col_q <= col_q + DIM_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else if (adv) begin
            tag_q.valid <= push && in_win;
            tag_q.last  <= push && in_win && end_row && end_col;
        end
    end

    assign tag_o = tag_q;

    // R9
    pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!push && !frame_start) |=> ($stable(col_q) && $stable(row_q)));

    // R2
    col_bound_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (col_q < img_w));

endmodule

// File: rtl/conv_window.sv
module conv_window
    import conv_pkg::*;
#(
    parameter int ROWS  = 2,
    parameter int COLS  = 3,
    parameter int MAX_W = 64
) (
    input  logic                         clk,
    input  logic                         push,
    input  logic [idx_width(MAX_W)-1:0]  col_idx,
    input  pix_t                         din,
    output pix_t                         win [ROWS][COLS]
);

    pix_t row_in [ROWS];

    assign row_in[0] = din;

    // One line store per older window row, read and written at the same column
    for (genvar r = 1; r < ROWS; r++) begin : g_line
        pix_t line_mem [MAX_W];

        assign row_in[r] = line_mem[col_idx];

        always_ff @(posedge clk) begin
            if (push) begin
                line_mem[col_idx] <= row_in[r-1];
            end
        end
    end

    // Column 0 of the window holds the newest pixel of each row
    always_ff @(posedge clk) begin
        if (push) begin
            for (int r = 0; r < ROWS; r++) begin
                win[r][0] <= row_in[r];
                for (int c = 1; c < COLS; c++) begin
                    win[r][c] <= win[r][c-1];
                end
            end
        end
    end

endmodule

// File: rtl/conv_mac.sv
module conv_mac
    import conv_pkg::*;
#(
    parameter int ROWS = 2,
    parameter int COLS = 3
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      en,
    input  pix_t                                      win [ROWS][COLS],
    input  pix_t                                      wts [ROWS*COLS],
    input  tag_t                                      tag_i,
    output logic signed [acc_width(ROWS,COLS)-1:0]    acc_o,
    output tag_t                                      tag_o
);

    localparam int ACC_W = acc_width(ROWS, COLS);

    prod_t                   prod_q [ROWS][COLS];
    logic signed [ACC_W-1:0] rsum_d [ROWS];
    logic signed [ACC_W-1:0] rsum_q [ROWS];
    logic signed [ACC_W-1:0] acc_d, acc_q;
    tag_t                    tag1_q, tag2_q, tag3_q;

    // Stage 1: all products at once; window [r][c] maps to weight row ROWS-1-r, column COLS-1-c
    always_ff @(posedge clk) begin
        if (en) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    prod_q[r][c] <= prod_t'(win[r][c]) *
                                    prod_t'(wts[(ROWS-1-r)*COLS + (COLS-1-c)]);
                end
            end
        end
    end

    // Stage 2: one partial sum per window row
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            rsum_d[r] = '0;
            for (int c = 0; c < COLS; c++) begin
                rsum_d[r] = rsum_d[r] + ACC_W'(prod_q[r][c]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (en) begin
            for (int r = 0; r < ROWS; r++) begin
                rsum_q[r] <= rsum_d[r];
            end
        end
    end

    // Stage 3: final sum
    always_comb begin
        acc_d = '0;
        for (int r = 0; r < ROWS; r++) begin
            acc_d = acc_d + rsum_q[r];
        end
    end

    always_ff @(posedge clk) begin
        if (en) begin
            acc_q <= acc_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag1_q <= '0;
            tag2_q <= '0;
            tag3_q <= '0;
        end else if (en) begin
            tag1_q <= tag_i;
            tag2_q <= tag1_q;
            tag3_q <= tag2_q;
        end
    end

    assign acc_o = acc_q;
    assign tag_o = tag3_q;

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tag3_q.valid && !en) |=> (tag3_q.valid && $stable(acc_q) && $stable(tag3_q.last)));

    // R7
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        tag3_q.last |-> tag3_q.valid);

endmodule

// File: rtl/conv_stream_engine.sv
module conv_stream_engine
    import conv_pkg::*;
#(
    parameter int ROWS  = 2,
    parameter int COLS  = 3,
    parameter int MAX_W = 64,
    parameter int DIM_W = 16
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    frame_start,
    input  logic [DIM_W-1:0]                        img_width,
    input  logic [DIM_W-1:0]                        img_height,
    input  logic                                    coef_we,
    input  logic [idx_width(ROWS*COLS)-1:0]         coef_addr,
    input  logic [PIX_W-1:0]                        coef_data,
    input  logic                                    pix_valid,
    output logic                                    pix_ready,
    input  logic [PIX_W-1:0]                        pix_data,
    output logic                                    res_valid,
    input  logic                                    res_ready,
    output logic signed [acc_width(ROWS,COLS)-1:0]  res_data,
    output logic                                    res_last
);

    localparam int TAPS  = ROWS * COLS;
    localparam int ACC_W = acc_width(ROWS, COLS);
    localparam int CW    = idx_width(MAX_W);

    logic          adv, push;
    logic [CW-1:0] col_idx;
    tag_t          tag_w, tag_out;
    pix_t          win [ROWS][COLS];
    pix_t          wts_q [TAPS];

    // Weight bank, row-major from the window's top-left
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < TAPS; k++) begin
                wts_q[k] <= '0;
            end
        end else if (coef_we) begin
            wts_q[coef_addr] <= pix_t'(coef_data);
        end
    end

    conv_ctrl #(
        .ROWS(ROWS), .COLS(COLS), .MAX_W(MAX_W), .DIM_W(DIM_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .img_w      (img_width),
        .img_h      (img_height),
        .in_valid   (pix_valid),
        .out_valid  (res_valid),
        .out_ready  (res_ready),
        .in_ready   (pix_ready),
        .adv        (adv),
        .push       (push),
        .col_idx    (col_idx),
        .tag_o      (tag_w)
    );

    conv_window #(
        .ROWS(ROWS), .COLS(COLS), .MAX_W(MAX_W)
    ) u_window (
        .clk    (clk),
        .push   (push),
        .col_idx(col_idx),
        .din    (pix_t'(pix_data)),
        .win    (win)
    );

    conv_mac #(
        .ROWS(ROWS), .COLS(COLS)
    ) u_mac (
        .clk  (clk),
        .rst  (rst),
        .en   (adv),
        .win  (win),
        .wts  (wts_q),
        .tag_i(tag_w),
        .acc_o(res_data),
        .tag_o(tag_out)
    );

    assign res_valid = tag_out.valid;
    assign res_last  = tag_out.last;

    // R4
    coef_addr_chk: assert property (@(posedge clk) disable iff (rst)
        coef_we |-> (int'(coef_addr) < TAPS));

endmodule

// File: tb/tb_conv_stream_engine.sv
`timescale 1ns/1ps
module tb_conv_stream_engine;
    import conv_pkg::*;

    localparam int ROWS  = 2;
    localparam int COLS  = 3;
    localparam int MAX_W = 64;
    localparam int DIM_W = 16;
    localparam int TAPS  = ROWS * COLS;
    localparam int ACC_W = acc_width(ROWS, COLS);
    localparam int AW    = idx_width(TAPS);

    typedef struct packed {
        int w; int h; int seed; int pat; int mode; int exp_cnt;
    } vec_t;

    // mode bit0: input gaps, bit1: random backpressure
    // pat 0 random, 1 all -128, 2 pixels 127 / weights -128, 3 one-hot weight
    localparam vec_t VEC [9] = '{
        '{5,  4, 1, 0, 0, 9},
        '{3,  2, 2, 0, 0, 1},
        '{8,  6, 3, 0, 1, 30},
        '{6,  3, 4, 0, 2, 8},
        '{16, 5, 5, 0, 3, 56},
        '{64, 3, 6, 0, 0, 124},
        '{4,  3, 7, 1, 0, 4},
        '{4,  3, 8, 2, 2, 4},
        '{7,  4, 9, 3, 0, 15}
    };

    logic clk = 0, rst = 1, frame_start = 0;
    logic [DIM_W-1:0] img_width = 3, img_height = 2;
    logic coef_we = 0;
    logic [AW-1:0] coef_addr = '0;
    logic [PIX_W-1:0] coef_data = '0;
    logic pix_valid = 0, pix_ready;
    logic [PIX_W-1:0] pix_data = '0;
    logic res_valid, res_ready = 1, res_last;
    logic signed [ACC_W-1:0] res_data;

    conv_stream_engine #(.ROWS(ROWS), .COLS(COLS), .MAX_W(MAX_W), .DIM_W(DIM_W)) dut (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .img_width(img_width), .img_height(img_height),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
        .res_valid(res_valid), .res_ready(res_ready),
        .res_data(res_data), .res_last(res_last)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_err = 0, cyc = 0;
    int unsigned lfsr = 32'h1ace_b00c;
    bit bp_on = 0, lat_on = 1, hold_pend = 0, hold_last = 0;
    logic signed [ACC_W-1:0] hold_data;
    string req_tag = "R2";

    pix_t img [0:1023];
    pix_t wm  [TAPS];
    int exp_val [0:255];
    int exp_br  [0:255];
    int acc_cyc [0:1023];
    int exp_n = 0, out_idx = 0;

    initial forever begin @(posedge clk); cyc++; end

    function int unsigned rnd();
        lfsr ^= lfsr << 13;
        lfsr ^= lfsr >> 17;
        lfsr ^= lfsr << 5;
        return lfsr;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic pix_t pix_of(int seed, int idx, int pat);
        if (pat == 1) return pix_t'(-128);
        if (pat == 2) return pix_t'(127);
        return pix_t'((seed * 73 + idx * 29 + (idx * idx) % 17) & 255);
    endfunction

    function automatic pix_t wt_of(int seed, int k, int pat);
        if (pat == 1 || pat == 2) return pix_t'(-128);
        if (pat == 3) return pix_t'((k == seed % TAPS) ? 1 : 0);
        return pix_t'((seed * 11 + k * 53 + 7) & 255);
    endfunction

    // Reference convolution, no padding, raster order of top-left corner
    task automatic build(int w, int h);
        exp_n = 0;
        for (int pr = 0; pr <= h - ROWS; pr++) begin
            for (int pc = 0; pc <= w - COLS; pc++) begin
                int s = 0;
                for (int i = 0; i < ROWS; i++)
                    for (int j = 0; j < COLS; j++)
                        s += int'(img[(pr + i) * w + pc + j]) * int'(wm[i * COLS + j]);
                exp_val[exp_n] = s;
                exp_br[exp_n]  = (pr + ROWS - 1) * w + pc + COLS - 1;
                exp_n++;
            end
        end
    endtask

    task automatic load_weights();
        for (int k = 0; k < TAPS; k++) begin
            @(negedge clk);
            coef_we = 1; coef_addr = AW'(k); coef_data = wm[k];
        end
        @(negedge clk);
        coef_we = 0;
    endtask

    task automatic send(int n, bit gaps);
        int idx = 0;
        while (idx < n) begin
            @(negedge clk);
            if (gaps && (rnd() % 3 == 0)) begin
                pix_valid = 0;
            end else begin
                pix_valid = 1;
                pix_data  = img[idx];
                #1;
                if (pix_ready) begin
                    acc_cyc[idx] = cyc + 1;
                    idx++;
                end
            end
        end
        @(negedge clk);
        pix_valid = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); frame_start = 1;
        @(negedge clk); frame_start = 0;
    endtask

    task automatic run_frame(int w, int h, int seed, int pat, int mode, int exp_cnt, bit do_start);
        int t = 0;
        img_width = DIM_W'(w); img_height = DIM_W'(h);
        for (int k = 0; k < TAPS; k++) wm[k] = wt_of(seed, k, pat);
        load_weights();
        for (int i = 0; i < w * h; i++) img[i] = pix_of(seed, i, pat);
        build(w, h);
        out_idx = 0;
        req_tag = (pat == 1 || pat == 2) ? "R5" : (pat == 3) ? "R4" : mode[0] ? "R8" : "R2";
        bp_on  = mode[1];
        lat_on = !mode[1];
        if (do_start) pulse_start();
        send(w * h, mode[0]);
        while (out_idx < exp_cnt && t < 5000) begin @(negedge clk); t++; end
        repeat (8) @(negedge clk);
        bp_on = 0;
        check(out_idx == exp_cnt, "R2", "result count", out_idx, exp_cnt);
    endtask

    // Downstream ready
    initial forever begin
        @(negedge clk);
        res_ready = bp_on ? (rnd() % 2 == 1) : 1'b1;
    end

    // Output monitor
    initial forever begin
        @(negedge clk); #2;
        if (hold_pend) begin
            check(res_valid && res_data == hold_data && res_last == hold_last,
                  "R6", "held output", res_data, hold_data);
            hold_pend = 0;
        end
        if (!rst && res_valid && !res_ready) begin
            check(!pix_ready, "R6", "pix_ready under stall", pix_ready, 0);
            hold_pend = 1; hold_data = res_data; hold_last = res_last;
        end
        if (!rst && res_valid && res_ready) begin
            if (out_idx < exp_n) begin
                check(res_data == exp_val[out_idx], req_tag, "result value", res_data, exp_val[out_idx]);
                check(res_last == (out_idx == exp_n - 1), "R7", "last flag", res_last, out_idx == exp_n - 1);
                if (lat_on)
                    check(cyc - acc_cyc[exp_br[out_idx]] == 3, "R3", "latency",
                          cyc - acc_cyc[exp_br[out_idx]], 3);
            end else begin
                check(0, "R2", "unexpected result", res_data, 0);
            end
            out_idx++;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #2;
        check(!res_valid && !res_last && pix_ready, "R1", "state in reset",
              {res_valid, res_last, pix_ready}, 3'b001);
        @(negedge clk); rst = 0;
        #2;
        check(!res_valid && !res_last && pix_ready, "R1", "state after reset",
              {res_valid, res_last, pix_ready}, 3'b001);

        for (int v = 0; v < 9; v++)
            run_frame(VEC[v].w, VEC[v].h, VEC[v].seed, VEC[v].pat, VEC[v].mode, VEC[v].exp_cnt, 1);

        // R9: abandon a partial frame, then restart with other dimensions
        exp_n = 0; out_idx = 0;
        img_width = 5; img_height = 4;
        pulse_start();
        for (int i = 0; i < 6; i++) img[i] = pix_of(20, i, 0);
        send(6, 0);
        repeat (6) @(negedge clk);
        check(out_idx == 0, "R9", "no output from partial frame", out_idx, 0);
        req_tag = "R9";
        run_frame(4, 3, 11, 0, 0, 4, 1);

        // R9: automatic wrap, second frame without a start pulse
        run_frame(5, 3, 12, 0, 0, 6, 1);
        run_frame(5, 3, 13, 0, 1, 6, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule